// File: doc/BRIEF.md
# Tick Counter with Compare Interrupts

This block keeps a free-running 63-bit tick count, plus a separate flag bit, and three comparators that watch that count. The count advances by one in each cycle where the count-enable strobe is high. Software reaches the counter through either of two register indices that select the same counter. A counter write does not stop the count. It moves an internal offset so that the value keeps counting up from the written value. A read returns the flag in bit 63 and the count with its two lowest bits cleared.

There are three comparators: tick, system tick and hypervisor system tick. Each holds a 64-bit compare word. Bit 63 of the word disables its interrupt and bits 62:0 hold the target. A comparator arms only when it is written with the disable bit clear and a target above the current count. An armed comparator fires once when the count equals the target. Firing sets a sticky pending bit, which drives that comparator's interrupt output until software clears it through the pending index.

Register access uses a request channel and a read-response channel, both valid/ready. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is held and `rsp_ready` is low, so a read result can never be overwritten. A request offered while `req_ready` is low has no effect. Writes produce no response.

Top module: `tick_cmp_unit`

## Requirements
- R1: After reset, both counter indices (0 and 1) read 0x8000_0000_0000_0000, meaning flag set and count zero. The three compare indices (2 tick, 3 system tick, 4 hypervisor) read 0x8000_0000_0000_0000. The pending index 5 reads zero and all interrupt outputs are low.
- R2: The count rises by one after each clock edge at which `cnt_en` is high and holds otherwise. A counter read returns count bits 62:2 in bits 62:2 and forces bits 1:0 to zero.
- R3: Indices 0 and 1 reach the same counter. A value written through one index is returned by a read through the other.
- R4: A counter write stores data bit 63 as the flag. After the write edge the count equals data bits 62:0 plus one if `cnt_en` was high in the write cycle, and it keeps counting from there.
- R5: A compare write with bit 63 clear and a target strictly greater than the current count arms that comparator. One edge after the count equals the target, that comparator's pending bit and interrupt output are high.
- R6: A comparator fires only once per arming. After its pending bit is cleared, further counting does not set the bit again until the comparator is re-armed by a new write.
- R7: A compare write with bit 63 set cancels any arming of that comparator, so it does not fire.
- R8: A compare write whose target is equal to or below the current count leaves the comparator disarmed.
- R9: Index 5 reads the pending bits in bits 2:0, ordered tick, system tick, hypervisor. Writing a one to a bit clears that pending bit. A fire in the same cycle as a clear wins, and the bit stays set.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold, and requests offered meanwhile are ignored.
- R11: Indices 6 and 7 read zero and ignore writes.
- R12: A compare index reads back the full 64-bit word last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count-enable strobe |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 3 | Register index |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read response held |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 64 | Read response data |
| irq_tick | output | 1 | Tick comparator pending |
| irq_stick | output | 1 | System-tick comparator pending |
| irq_hstick | output | 1 | Hypervisor comparator pending |

## Verification
The assertions assume that all inputs carry known values from the first edge after reset. The count-step properties also assume that the 63-bit count does not wrap within a run. The stimulus changes every input only on the falling edge, and it keeps the count in the low thousands, far from wrap. The response-hold property relies on `rsp_ready` being driven by the consumer and not derived from `rsp_valid`. The bench therefore holds `rsp_ready` as a plain level, and it drops that level only in the back-pressure test.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int DATA_W  = 64;
  localparam int TGT_W   = DATA_W - 1;
  localparam int IDX_W   = 3;
  localparam int NUM_CMP = 3;

  typedef enum logic [IDX_W-1:0] {
    IX_TICK   = 3'd0,
    IX_STICK  = 3'd1,
    IX_CMP_T  = 3'd2,
    IX_CMP_S  = 3'd3,
    IX_CMP_H  = 3'd4,
    IX_PEND   = 3'd5
  } reg_idx_e;

  localparam logic [IDX_W-1:0] CMP_BASE = IX_CMP_T;
  localparam logic [DATA_W-1:0] CMP_RESET = {1'b1, {TGT_W{1'b0}}};
endpackage

// File: rtl/tick_counter.sv
module tick_counter
  import tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_data,
  output logic              flag,
  output logic [TGT_W-1:0]  count
);
  logic [TGT_W-1:0] raw_q;
  logic [TGT_W-1:0] off_q;
  logic             flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      off_q  <= '0;
      flag_q <= 1'b1;
    end else begin
      raw_q <= raw_q + TGT_W'(en);
      if (ld) begin
        off_q  <= raw_q - ld_data[TGT_W-1:0];
        flag_q <= ld_data[DATA_W-1];
      end
    end
  end

  assign count = raw_q - off_q;
  assign flag  = flag_q;

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en && !ld |=> count == $past(count) + TGT_W'(1));
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !ld |=> $stable(count));
  p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> count == $past(ld_data[TGT_W-1:0]) + TGT_W'($past(en)));
  p_load_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> flag == $past(ld_data[DATA_W-1]));
endmodule

// File: rtl/tick_comparator.sv
module tick_comparator
  import tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  input  logic [TGT_W-1:0]  count,
  output logic [DATA_W-1:0] cfg,
  output logic              pend
);
  logic [DATA_W-1:0] cfg_q;
  logic              armed_q;
  logic              pend_q;
  logic              hit;

  assign hit = armed_q && (count == cfg_q[TGT_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= CMP_RESET;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (wr) begin
        cfg_q   <= wdata;
        armed_q <= !wdata[DATA_W-1] && (wdata[TGT_W-1:0] > count);
      end else if (hit) begin
        armed_q <= 1'b0;
      end
      if (hit)      pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
    end
  end

  assign cfg  = cfg_q;
  assign pend = pend_q;

  p_fire_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && count == cfg_q[TGT_W-1:0] |=> pend);
  p_fire_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !wr |=> !armed_q);
  p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr && wdata[DATA_W-1] |=> !armed_q);
  p_pend_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(armed_q));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> $past(clr));
endmodule

// File: rtl/tick_regport.sv
module tick_regport
  import tick_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [IDX_W-1:0]              req_idx,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [DATA_W-1:0]             rsp_rdata,
  input  logic                          cnt_flag,
  input  logic [TGT_W-1:0]              cnt_value,
  input  logic [NUM_CMP-1:0][DATA_W-1:0] cmp_cfg,
  input  logic [NUM_CMP-1:0]            cmp_pend,
  output logic                          cnt_ld,
  output logic [NUM_CMP-1:0]            cmp_wr,
  output logic [NUM_CMP-1:0]            cmp_clr
);
  logic              accept;
  logic              wr_acc;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] tick_word;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_acc    = accept && req_write;

  assign tick_word = {cnt_flag, cnt_value[TGT_W-1:2], 2'b00};
  assign cnt_ld    = wr_acc && (req_idx == IX_TICK || req_idx == IX_STICK);

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp_dec
    assign cmp_wr[i]  = wr_acc && (req_idx == CMP_BASE + IDX_W'(i));
    assign cmp_clr[i] = wr_acc && (req_idx == IX_PEND) && req_wdata[i];
  end

  always_comb begin
    rd_word = '0;
    if (req_idx == IX_TICK || req_idx == IX_STICK) begin
      rd_word = tick_word;
    end else if (req_idx == IX_PEND) begin
      rd_word = DATA_W'(cmp_pend);
    end else begin
      for (int i = 0; i < NUM_CMP; i++) begin
        if (req_idx == CMP_BASE + IDX_W'(i)) rd_word = cmp_cfg[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (accept && !req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  p_stall_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cnt_ld, cmp_wr}) <= 1);
endmodule

// File: rtl/tick_cmp_unit.sv
module tick_cmp_unit
  import tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_tick,
  output logic              irq_stick,
  output logic              irq_hstick
);
  logic                           cnt_flag;
  logic [TGT_W-1:0]               cnt_value;
  logic                           cnt_ld;
  logic [NUM_CMP-1:0][DATA_W-1:0] cmp_cfg;
  logic [NUM_CMP-1:0]             cmp_pend;
  logic [NUM_CMP-1:0]             cmp_wr;
  logic [NUM_CMP-1:0]             cmp_clr;

  tick_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cnt_en),
    .ld      (cnt_ld),
    .ld_data (req_wdata),
    .flag    (cnt_flag),
    .count   (cnt_value)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    tick_comparator u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cmp_wr[i]),
      .wdata (req_wdata),
      .clr   (cmp_clr[i]),
      .count (cnt_value),
      .cfg   (cmp_cfg[i]),
      .pend  (cmp_pend[i])
    );
  end

  tick_regport u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_idx   (req_idx),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .cnt_flag  (cnt_flag),
    .cnt_value (cnt_value),
    .cmp_cfg   (cmp_cfg),
    .cmp_pend  (cmp_pend),
    .cnt_ld    (cnt_ld),
    .cmp_wr    (cmp_wr),
    .cmp_clr   (cmp_clr)
  );

  assign irq_tick   = cmp_pend[0];
  assign irq_stick  = cmp_pend[1];
  assign irq_hstick = cmp_pend[2];
endmodule

// File: tb/tick_cmp_unit_test.sv
module tick_cmp_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid;
  logic [63:0] rsp_rdata;
  logic        irq_tick, irq_stick, irq_hstick;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [63:0] got;
  logic [63:0] held;

  localparam logic [63:0] TOP = 64'h8000_0000_0000_0000;

  // {write, idx, data, expected read}
  localparam int NV = 16;
  localparam logic [131:0] VEC [NV] = '{
    {1'b0, 3'd0, 64'h0, TOP},                    // R1 counter
    {1'b0, 3'd1, 64'h0, TOP},                    // R1 alias
    {1'b0, 3'd2, 64'h0, TOP},                    // R1 cmp tick
    {1'b0, 3'd3, 64'h0, TOP},                    // R1 cmp sys
    {1'b0, 3'd4, 64'h0, TOP},                    // R1 cmp hyp
    {1'b0, 3'd5, 64'h0, 64'h0},                  // R1 pending
    {1'b1, 3'd1, 64'h7, 64'h0},                  // R3 write via alias
    {1'b0, 3'd0, 64'h0, 64'h4},                  // R2 low bits dropped
    {1'b1, 3'd0, 64'h8000_0000_0000_0123, 64'h0},// R4 flag set
    {1'b0, 3'd1, 64'h0, 64'h8000_0000_0000_0120},// R3 R4
    {1'b1, 3'd6, 64'hff, 64'h0},                 // R11
    {1'b0, 3'd6, 64'h0, 64'h0},                  // R11
    {1'b0, 3'd7, 64'h0, 64'h0},                  // R11
    {1'b1, 3'd2, 64'h8000_0000_0000_0055, 64'h0},// R12
    {1'b0, 3'd2, 64'h0, 64'h8000_0000_0000_0055},// R12
    {1'b1, 3'd4, 64'h8000_0000_0000_abcd, 64'h0} // R12
  };

  tick_cmp_unit uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_idx(req_idx), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_tick(irq_tick), .irq_stick(irq_stick), .irq_hstick(irq_hstick)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 20000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] idx, input logic [63:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_idx = idx; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] idx, output logic [63:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_idx = idx;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic run(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq lines", {61'd0, irq_hstick, irq_stick, irq_tick}, 64'd0);
    chk("R10 ready after reset", {63'd0, req_ready}, 64'd1);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][131]) begin
        do_write(VEC[k][130:128], VEC[k][127:64]);
      end else begin
        do_read(VEC[k][130:128], got);
        chk($sformatf("R1-table row %0d (R2 R3 R4 R11 R12)", k), got, VEC[k][63:0]);
      end
    end
    do_read(3'd4, got);
    chk("R12 hyp cmp readback", got, 64'h8000_0000_0000_abcd);

    // R2 counting
    do_write(3'd0, 64'h10);
    run(5);
    do_read(3'd0, got);
    chk("R2 count 0x15 reads 0x14", got, 64'h14);
    // R4 write while counting
    cnt_en = 1'b1;
    do_write(3'd0, 64'h20);
    cnt_en = 1'b0;
    run(2);
    do_read(3'd0, got);
    chk("R4 write during enable +1 then +2", got, 64'h20);
    run(1);
    do_read(3'd0, got);
    chk("R4 count 0x24", got, 64'h24);

    // R5 tick comparator
    do_write(3'd0, 64'd100);
    do_write(3'd2, 64'd103);
    run(3);
    chk("R5 not yet pending at match", {63'd0, irq_tick}, 64'd0);
    @(negedge clk);
    chk("R5 tick irq set", {63'd0, irq_tick}, 64'd1);
    do_read(3'd5, got);
    chk("R9 pending bit0", got, 64'd1);
    // R6 clear and no refire
    do_write(3'd5, 64'd1);
    chk("R9 cleared", {63'd0, irq_tick}, 64'd0);
    do_write(3'd0, 64'd100);
    run(6);
    chk("R6 no refire", {63'd0, irq_tick}, 64'd0);

    // R5 system tick, R7 cancel on hyp
    do_write(3'd0, 64'd500);
    do_write(3'd3, 64'd502);
    do_write(3'd4, 64'd501);
    do_write(3'd4, 64'h8000_0000_0000_01f5);
    run(2);
    @(negedge clk);
    chk("R5 stick irq", {63'd0, irq_stick}, 64'd1);
    chk("R7 cancelled hyp", {63'd0, irq_hstick}, 64'd0);
    do_read(3'd5, got);
    chk("R9 pending bit1 only", got, 64'd2);

    // R8 target not in future
    do_write(3'd5, 64'd7);
    do_write(3'd0, 64'd700);
    do_write(3'd2, 64'd700);
    do_write(3'd4, 64'd650);
    run(3);
    @(negedge clk);
    chk("R8 equal target disarmed", {63'd0, irq_tick}, 64'd0);
    chk("R8 past target disarmed", {63'd0, irq_hstick}, 64'd0);

    // R9 set wins over clear
    do_write(3'd4, 64'd704);
    run(1);
    do_write(3'd5, 64'd4);
    chk("R9 fire beats clear", {63'd0, irq_hstick}, 64'd1);
    do_write(3'd5, 64'd4);
    chk("R9 later clear", {63'd0, irq_hstick}, 64'd0);

    // R10 back-pressure
    do_write(3'd0, 64'h40);
    rsp_ready = 1'b0;
    do_read(3'd0, held);
    chk("R10 held data", held, 64'h40);
    chk("R10 ready low", {63'd0, req_ready}, 64'd0);
    req_valid = 1'b1; req_write = 1'b1; req_idx = 3'd0; req_wdata = 64'h5555;
    cnt_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 data stable", rsp_rdata, held);
      chk("R10 valid held", {63'd0, rsp_valid}, 64'd1);
    end
    req_valid = 1'b0; req_write = 1'b0; cnt_en = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 response consumed", {63'd0, rsp_valid}, 64'd0);
    do_read(3'd0, got);
    chk("R10 stalled write ignored", got, 64'h44);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule